// File: doc/BRIEF.md
# Interrupt Arbitration and Vector Unit

This block sits beside the sequencer of an 8-bit processor. It decides when an interrupt sequence should begin. Three request levels come in: non-maskable, fast and normal. The fast and normal requests are gated by two mask bits taken from the condition-code register.

At each instruction-boundary strobe the block picks the most urgent unmasked request. One clock later it reports the following:
- a one-cycle take pulse;
- the identity of the chosen interrupt;
- the vector address from which the new program counter is fetched;
- an 8-bit mask of the registers to push;
- a set or clear command for the entire-state flag.

The sequencer does the pushing and the vector read itself.

While the processor waits in its synchronise state, the block watches how long the winning request has been high. Each source keeps a short level history. A request seen high on the previous three clocks is serviced in full. A shorter one only ends the wait: the block emits a resume pulse, discards that source's history and does not service the request.

Top module: `irq_arbiter`

## Requirements
- R1: When `boundary` is high and `sync_wait` is low, the winner is the first pending request in this order: non-maskable, then fast, then normal. If nothing is pending, no take pulse follows.
- R2: The fast request counts as pending only while `fast_mask` is 0. The normal request counts as pending only while `norm_mask` is 0. The non-maskable request is pending whenever `nmi_lvl` is high.
- R3: On a take, `vec_o` is 16'hFFFC for non-maskable, 16'hFFF6 for fast and 16'hFFF8 for normal. `take_id_o` is 1 for non-maskable, 2 for fast and 3 for normal.
- R4: A non-maskable or normal take drives `stack_o` = 8'hFF and pulses `eset_o`. A fast take drives `stack_o` = 8'h81 and pulses `eclr_o`.
- R5: All outputs change on the clock edge that samples the deciding inputs. In any cycle without a take, `take_id_o`, `vec_o`, `stack_o`, `eset_o` and `eclr_o` are zero.
- R6: Each source's 3-bit history shifts in its raw request level on every clock. The history of a source is cleared to zero on the edge where that source wins, whether the win leads to a take or a resume.
- R7: With `sync_wait` high, a winner whose request was high on each of the previous three clocks produces a full take, as in R3 and R4.
- R8: With `sync_wait` high, a winner with a shorter history produces a one-cycle `resume_o` pulse with all other outputs zero, and no take.
- R9: With `sync_wait` high and nothing pending, neither a take nor a resume is produced.
- R10: A synchronous active-high `rst` clears all histories and drives every output to zero.
- R11: When `sync_wait` and `boundary` are both high, the rules for `sync_wait` apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_lvl | input | 1 | Non-maskable request level |
| fast_lvl | input | 1 | Fast request level |
| norm_lvl | input | 1 | Normal request level |
| fast_mask | input | 1 | 1 blocks the fast request |
| norm_mask | input | 1 | 1 blocks the normal request |
| boundary | input | 1 | Instruction boundary strobe |
| sync_wait | input | 1 | Processor is waiting in synchronise state |
| take_o | output | 1 | Start interrupt sequence (one cycle) |
| take_id_o | output | 2 | Interrupt identity: 0 none, 1 NMI, 2 fast, 3 normal |
| vec_o | output | 16 | Vector address |
| stack_o | output | 8 | Registers to push |
| eset_o | output | 1 | Set entire-state flag |
| eclr_o | output | 1 | Clear entire-state flag |
| resume_o | output | 1 | Leave the wait without service |

## Verification
The assertions assume that the mask bits and strobes are clean levels, sampled once per clock. They also assume that what the block decided in the previous cycle is visible through `$past` of those inputs. The bench drives every input on the falling edge, so each rising edge sees one settled set of values. Request pulses of one, two, three and four clocks are applied around the synchronise state so that both sides of the three-clock threshold are reached.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_FAST = 2'd2,
        SRC_NORM = 2'd3
    } src_e;

    localparam int NSRC = 3;

    typedef struct packed {
        logic        take;
        logic        resume;
        src_e        id;
        logic [15:0] vec;
        logic [7:0]  stk;
        logic        e_set;
        logic        e_clr;
    } verdict_t;

    // index 1 is the fast source: it pushes only PC and CC
    function automatic logic [7:0] stack_of(input int unsigned idx);
        return (idx == 1) ? 8'h81 : 8'hFF;
    endfunction

endpackage

// File: rtl/irq_history.sv
module irq_history #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         lvl,
    input  logic         clr,
    output logic         full_o
);
    logic [W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            hist_q <= '0;
        else
            hist_q <= {hist_q[W-2:0], lvl};
    end

    assign full_o = &hist_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
#(
    parameter logic [15:0] VEC_NMI  = 16'hFFFC,
    parameter logic [15:0] VEC_FAST = 16'hFFF6,
    parameter logic [15:0] VEC_NORM = 16'hFFF8
) (
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] full,
    input  logic            boundary,
    input  logic            sync_wait,
    output verdict_t        verdict,
    output logic [NSRC-1:0] clr
);
    logic [15:0] vec_tab [NSRC];
    logic [1:0]  widx;
    logic        any;

    assign vec_tab[0] = VEC_NMI;
    assign vec_tab[1] = VEC_FAST;
    assign vec_tab[2] = VEC_NORM;
    assign any = |pend;

    always_comb begin
        if (pend[0])      widx = 2'd0;
        else if (pend[1]) widx = 2'd1;
        else              widx = 2'd2;
    end

    always_comb begin
        logic do_take;
        verdict = '0;
        clr     = '0;
        do_take = 1'b0;
        if (any && sync_wait) begin
            clr[widx] = 1'b1;
            if (full[widx]) do_take = 1'b1;
            else            verdict.resume = 1'b1;
        end else if (any && boundary) begin
            clr[widx] = 1'b1;
            do_take   = 1'b1;
        end
        if (do_take) begin
            verdict.take  = 1'b1;
            verdict.id    = src_e'(widx + 2'd1);
            verdict.vec   = vec_tab[widx];
            verdict.stk   = stack_of(int'(widx));
            verdict.e_set = (widx != 2'd1);
            verdict.e_clr = (widx == 2'd1);
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int          HIST_W   = 3,
    parameter logic [15:0] VEC_NMI  = 16'hFFFC,
    parameter logic [15:0] VEC_FAST = 16'hFFF6,
    parameter logic [15:0] VEC_NORM = 16'hFFF8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        nmi_lvl,
    input  logic        fast_lvl,
    input  logic        norm_lvl,
    input  logic        fast_mask,
    input  logic        norm_mask,
    input  logic        boundary,
    input  logic        sync_wait,
    output logic        take_o,
    output logic [1:0]  take_id_o,
    output logic [15:0] vec_o,
    output logic [7:0]  stack_o,
    output logic        eset_o,
    output logic        eclr_o,
    output logic        resume_o
);
    logic [NSRC-1:0] lvl, pend, full, clr;
    verdict_t        verdict, out_q;

    assign lvl  = {norm_lvl, fast_lvl, nmi_lvl};
    assign pend = {norm_lvl & ~norm_mask, fast_lvl & ~fast_mask, nmi_lvl};

    for (genvar i = 0; i < NSRC; i++) begin : g_hist
        irq_history #(.W(HIST_W)) u_hist (
            .clk    (clk),
            .rst    (rst),
            .lvl    (lvl[i]),
            .clr    (clr[i]),
            .full_o (full[i])
        );
    end

    irq_pick #(
        .VEC_NMI  (VEC_NMI),
        .VEC_FAST (VEC_FAST),
        .VEC_NORM (VEC_NORM)
    ) u_pick (
        .pend      (pend),
        .full      (full),
        .boundary  (boundary),
        .sync_wait (sync_wait),
        .verdict   (verdict),
        .clr       (clr)
    );

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= verdict;
    end

    assign take_o    = out_q.take;
    assign take_id_o = out_q.id;
    assign vec_o     = out_q.vec;
    assign stack_o   = out_q.stk;
    assign eset_o    = out_q.e_set;
    assign eclr_o    = out_q.e_clr;
    assign resume_o  = out_q.resume;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk (
    input logic        clk,
    input logic        rst,
    input logic        fast_mask,
    input logic        norm_mask,
    input logic        boundary,
    input logic        sync_wait,
    input logic        take_o,
    input logic [1:0]  take_id_o,
    input logic [15:0] vec_o,
    input logic [7:0]  stack_o,
    input logic        eset_o,
    input logic        eclr_o,
    input logic        resume_o
);
    a_r8_take_resume_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(take_o && resume_o));

    a_r2_fast_gated: assert property (@(posedge clk) disable iff (rst)
        (take_o && take_id_o == 2'd2) |-> !$past(fast_mask));

    a_r2_norm_gated: assert property (@(posedge clk) disable iff (rst)
        (take_o && take_id_o == 2'd3) |-> !$past(norm_mask));

    a_r3_nmi_vector: assert property (@(posedge clk) disable iff (rst)
        (take_o && take_id_o == 2'd1) |-> (vec_o == 16'hFFFC));

    a_r4_fast_stack: assert property (@(posedge clk) disable iff (rst)
        (take_o && take_id_o == 2'd2) |-> (stack_o == 8'h81 && eclr_o && !eset_o));

    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (vec_o == 16'h0 && stack_o == 8'h0 && !eset_o && !eclr_o));

    a_r1_take_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(boundary || sync_wait));

    a_r8_resume_needs_sync: assert property (@(posedge clk) disable iff (rst)
        resume_o |-> $past(sync_wait));
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fast_mask (fast_mask),
    .norm_mask (norm_mask),
    .boundary  (boundary),
    .sync_wait (sync_wait),
    .take_o    (take_o),
    .take_id_o (take_id_o),
    .vec_o     (vec_o),
    .stack_o   (stack_o),
    .eset_o    (eset_o),
    .eclr_o    (eclr_o),
    .resume_o  (resume_o)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nmi_lvl = 0, fast_lvl = 0, norm_lvl = 0;
    logic fast_mask = 0, norm_mask = 0, boundary = 0, sync_wait = 0;
    logic        take_o, eset_o, eclr_o, resume_o;
    logic [1:0]  take_id_o;
    logic [15:0] vec_o;
    logic [7:0]  stack_o;

    int checks = 0;
    int fails  = 0;
    int run_len [3];

    always #2.5 clk = ~clk;

    irq_arbiter u0 (
        .clk(clk), .rst(rst),
        .nmi_lvl(nmi_lvl), .fast_lvl(fast_lvl), .norm_lvl(norm_lvl),
        .fast_mask(fast_mask), .norm_mask(norm_mask),
        .boundary(boundary), .sync_wait(sync_wait),
        .take_o(take_o), .take_id_o(take_id_o), .vec_o(vec_o),
        .stack_o(stack_o), .eset_o(eset_o), .eclr_o(eclr_o),
        .resume_o(resume_o)
    );

    task automatic compare(input string tag, input logic e_take, input logic e_res,
                           input logic [1:0] e_id, input logic [15:0] e_vec,
                           input logic [7:0] e_stk, input logic e_es, input logic e_ec);
        checks++;
        if (take_o !== e_take || resume_o !== e_res || take_id_o !== e_id ||
            vec_o !== e_vec || stack_o !== e_stk || eset_o !== e_es || eclr_o !== e_ec) begin
            fails++;
            $display("FAIL %s: got take=%b res=%b id=%0d vec=%h stk=%h es=%b ec=%b, expected take=%b res=%b id=%0d vec=%h stk=%h es=%b ec=%b",
                     tag, take_o, resume_o, take_id_o, vec_o, stack_o, eset_o, eclr_o,
                     e_take, e_res, e_id, e_vec, e_stk, e_es, e_ec);
        end
    endtask

    // One clock: drive at falling edge, predict, let a rising edge pass, check.
    task automatic cyc(input logic n, input logic f, input logic nm,
                       input logic fm, input logic nmm, input logic b,
                       input logic s, input string tag);
        logic p [3];
        logic l [3];
        int w, clear;
        logic e_take, e_res, e_es, e_ec;
        logic [1:0] e_id;
        logic [15:0] e_vec;
        logic [7:0] e_stk;
        nmi_lvl = n; fast_lvl = f; norm_lvl = nm;
        fast_mask = fm; norm_mask = nmm; boundary = b; sync_wait = s;
        l[0] = n; l[1] = f; l[2] = nm;
        p[0] = n; p[1] = f && !fm; p[2] = nm && !nmm;
        w = -1;
        for (int i = 0; i < 3; i++) if (p[i] && w < 0) w = i;
        e_take = 0; e_res = 0; e_id = 0; e_vec = 0; e_stk = 0; e_es = 0; e_ec = 0;
        clear = -1;
        if (w >= 0 && (s || b)) begin
            clear = w;
            if (s && run_len[w] < 3) e_res = 1;
            else begin
                e_take = 1;
                e_id   = 2'(w + 1);
                e_vec  = (w == 0) ? 16'hFFFC : (w == 1) ? 16'hFFF6 : 16'hFFF8;
                e_stk  = (w == 1) ? 8'h81 : 8'hFF;
                e_es   = (w != 1);
                e_ec   = (w == 1);
            end
        end
        for (int i = 0; i < 3; i++) begin
            if (i == clear)  run_len[i] = 0;
            else if (l[i])   run_len[i] = (run_len[i] < 3) ? run_len[i] + 1 : 3;
            else             run_len[i] = 0;
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag, e_take, e_res, e_id, e_vec, e_stk, e_es, e_ec);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) run_len[i] = 0;
        // R10: reset with requests present
        nmi_lvl = 1; boundary = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        compare("R10 reset", 0, 0, 0, 0, 0, 0, 0);
        rst = 0; nmi_lvl = 0; boundary = 0;
        for (int i = 0; i < 3; i++) run_len[i] = 0;

        cyc(0,0,0, 0,0, 1,0, "R1 idle boundary");
        cyc(1,1,1, 0,0, 1,0, "R1 R3 R4 nmi wins");
        cyc(0,1,1, 0,0, 1,0, "R1 R4 fast wins");
        cyc(0,0,1, 0,0, 1,0, "R3 R4 normal take");
        cyc(0,1,1, 1,0, 1,0, "R2 fast masked");
        cyc(0,1,1, 1,1, 1,0, "R2 both masked");
        cyc(1,1,1, 1,1, 1,0, "R2 nmi ungated");
        cyc(0,1,0, 0,0, 0,0, "R5 no strobe");
        cyc(0,0,0, 0,0, 0,0, "R5 quiet");
        // R7: normal high three clocks, then sync
        cyc(0,0,1, 0,0, 0,0, "R6 build 1");
        cyc(0,0,1, 0,0, 0,0, "R6 build 2");
        cyc(0,0,1, 0,0, 0,0, "R6 build 3");
        cyc(0,0,1, 0,0, 0,1, "R7 long sync take");
        cyc(0,0,1, 0,0, 0,1, "R6 R8 cleared after take");
        cyc(0,0,0, 0,0, 0,1, "R9 sync no request");
        cyc(0,1,0, 0,0, 0,1, "R8 short fast");
        cyc(0,1,0, 0,0, 0,0, "R6 fast 1");
        cyc(0,1,0, 0,0, 0,0, "R6 fast 2");
        cyc(0,1,0, 0,0, 0,1, "R6 R8 two clocks only");
        cyc(0,1,0, 0,0, 0,0, "R6 fast a");
        cyc(0,1,0, 0,0, 0,0, "R6 fast b");
        cyc(0,1,0, 0,0, 0,0, "R6 fast c");
        cyc(0,1,0, 0,0, 0,1, "R7 R4 fast sync take");
        cyc(0,0,0, 0,0, 0,0, "R5 gap");
        cyc(1,0,0, 0,0, 1,1, "R11 sync over boundary");
        cyc(1,0,0, 0,0, 0,0, "R6 nmi 1");
        cyc(1,0,0, 0,0, 0,0, "R6 nmi 2");
        cyc(1,0,0, 0,0, 1,0, "R6 nmi boundary take");
        cyc(1,0,0, 0,0, 0,1, "R6 history cleared by take");
        cyc(0,0,1, 0,1, 0,1, "R2 R9 masked in sync");
        cyc(0,0,1, 0,1, 0,0, "R6 masked history");
        cyc(0,0,1, 0,0, 0,1, "R7 history kept while masked");
        cyc(0,0,0, 0,0, 0,0, "R5 end");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule